// File: doc/BRIEF.md
# Quad Potentiometer Two-Wire Write Slave

This block is the slave side of a two-wire serial bus in front of four digital potentiometer channels. It watches SCL and SDA, decodes a device byte and a register byte, and takes one data byte per transfer. Each channel has a volatile wiper register that drives the wiper output. Each channel also has a small bank of data registers, arranged in rows, that stand in for nonvolatile memory. A separate status register picks the active row and says whether nonvolatile access is enabled.

The bus pins are oversampled in the system clock domain. Writing a data register also reloads every wiper from the written row. It then starts a modelled internal write cycle after STOP. For the length of that cycle the slave leaves SDA released and acknowledges nothing. The write-protect pin must be high for a data register write to be allowed. The hardware address pins and the write-protect pin are treated as static straps.

Top module: `qpot_twowire_slave`

## Requirements
- R1: After reset all wiper outputs are zero and the SDA pull-down enable is low.
- R2: The device byte is acknowledged only when its upper nibble is 0101, bits 3..1 equal hw_addr_i[2:0] and bit 0 is 0. When it does not match, the slave acknowledges no further byte and changes nothing until the next START.
- R3: A device byte with bit 0 set (read request) is not acknowledged, even when the address bits match.
- R4: The register byte is acknowledged when bits 7..3 are zero and bits 2..0 are 0 to 3 (a channel) or 7 (status). Values 4 to 6, or any nonzero upper bit, get no acknowledge, and the transfer is dropped with no register change.
- R5: A channel write while status bit 0 is clear, or while wp_i is low, changes only that channel's wiper. The new value shows on wiper_o after the acknowledge slot of the data byte begins.
- R6: A status write stores bit 0 as nonvolatile-enable and bit 1 as row select. In the same acknowledge slot, every wiper loads its data register from the newly selected row.
- R7: A channel write while status bit 0 and wp_i are both high stores the byte in that channel's data register of the selected row and in its wiper. Every other wiper loads its own data register from that row.
- R8: After the STOP of a transfer that wrote a data register, the slave is busy for NV_CYCLES clocks. While busy it acknowledges no device byte, and afterwards it acknowledges again.
- R9: After the STOP of a wiper-only or status write, the very next transfer is acknowledged.
- R10: SDA is pulled low only in acknowledge slots. The pull starts at the SCL fall after the eighth bit and ends at the SCL fall after the ninth. A byte sent after the data byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| wp_i | input | 1 | Write-protect pin, high permits data register writes |
| hw_addr_i | input | 3 | Hardware address straps, compared with device byte bits 3..1 |
| sda_pull_o | output | 1 | High drives the SDA line low (acknowledge) |
| wiper_o | output | NUM_CH*8 | Wiper values, channel n in bits 8n+7..8n |

## Verification
The bench drives whole byte-write transfers and keeps a behavioural model of the wipers, data rows, status and busy window. It compares the wiper outputs on every clock and the acknowledge bit at each ninth clock. Device bytes with a wrong nibble, wrong strap bits or the read bit set show whether the match is exact. Register bytes 4 to 6 and bytes with upper bits set show whether the address filter is exact. Wiper-only writes under different protect and enable settings are set against data row writes and row-switching status writes. The wiper patterns that result show apart a single-wiper update, a whole-row reload and a write to the wrong row. A transfer right after a data row write, another after the busy window, and an extra byte after the data byte show apart the busy gating, the immediate ready state and the acknowledge slot timing.

// File: rtl/qpot_pkg.sv
// Shared constants and types for the quad potentiometer two-wire slave.
// Assumes bus bytes are eight bits and that the status register sits at select 7.
package qpot_pkg;
    localparam int BYTE_W = 8;
    localparam logic [2:0] ADDR_STATUS = 3'd7;

    typedef enum logic [1:0] {
        SLOT_DEV  = 2'd0,
        SLOT_ADDR = 2'd1,
        SLOT_DATA = 2'd2,
        SLOT_TAIL = 2'd3
    } byte_slot_t;
endpackage

// File: rtl/qpot_bus_front.sv
// Bus front end: brings SCL and SDA into the clk domain through a flop chain
// and derives single-cycle SCL edge, START and STOP pulses.
// Assumes clk runs many times faster than SCL; the lines idle high.
module qpot_bus_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [SYNC_STAGES:0] scl_sh;
    logic [SYNC_STAGES:0] sda_sh;
    logic scl_s, scl_d, sda_s, sda_d;

    // Shift the raw pins through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
        end
    end

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign scl_d = scl_sh[SYNC_STAGES];
    assign sda_s = sda_sh[SYNC_STAGES-1];
    assign sda_d = sda_sh[SYNC_STAGES];

    // Edge and condition decode on the synchronised samples.
    always_comb begin
        sda_o      = sda_s;
        scl_rise_o = scl_s & ~scl_d;
        scl_fall_o = ~scl_s & scl_d;
        start_o    = scl_s & scl_d & sda_d & ~sda_s;
        stop_o     = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/qpot_byte_engine.sv
// Byte engine: shifts in bits on SCL rise, decides the acknowledge at the SCL
// fall after the eighth bit, and walks device, register and data bytes.
// Issues one write strobe per accepted data byte. Assumes the front end
// pulses are single-cycle and mutually exclusive in practice.
module qpot_byte_engine import qpot_pkg::*; #(
    parameter int         NUM_CH  = 4,
    parameter logic [3:0] DEV_TAG = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [2:0]        hw_addr_i,
    input  logic              busy_i,
    output logic              ack_o,
    output logic              wr_stb_o,
    output logic [2:0]        wr_sel_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam logic [2:0] CH_LIMIT = 3'(NUM_CH);

    logic              active_q;
    logic              ack_q;
    byte_slot_t        slot_q;
    logic [3:0]        bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [2:0]        sel_q;
    logic              wr_stb_q;
    logic [BYTE_W-1:0] wr_data_q;
    logic              dev_ok;
    logic              addr_ok;
    byte_slot_t        slot_next;

    // Match rules for the device and register bytes.
    always_comb begin
        dev_ok  = !busy_i && (shreg_q[7:4] == DEV_TAG) &&
                  (shreg_q[3:1] == hw_addr_i) && !shreg_q[0];
        addr_ok = (shreg_q[7:3] == 5'd0) &&
                  ((shreg_q[2:0] == ADDR_STATUS) || (shreg_q[2:0] < CH_LIMIT));
    end

    // Byte order within one transfer.
    always_comb begin
        case (slot_q)
            SLOT_DEV:  slot_next = SLOT_ADDR;
            SLOT_ADDR: slot_next = SLOT_DATA;
            default:   slot_next = SLOT_TAIL;
        endcase
    end

    // Transfer sequencing, bit shifting and acknowledge control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            ack_q     <= 1'b0;
            slot_q    <= SLOT_DEV;
            bit_cnt_q <= 4'd0;
            shreg_q   <= '0;
            sel_q     <= 3'd0;
            wr_stb_q  <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_stb_q <= 1'b0;
            if (start_i) begin
                active_q  <= 1'b1;
                slot_q    <= SLOT_DEV;
                bit_cnt_q <= 4'd0;
                ack_q     <= 1'b0;
            end else if (stop_i) begin
                active_q  <= 1'b0;
                bit_cnt_q <= 4'd0;
                ack_q     <= 1'b0;
            end else if (active_q) begin
                if (scl_rise_i) begin
                    if (bit_cnt_q < 4'd8) begin
                        shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end else if (bit_cnt_q == 4'd8) begin
                        bit_cnt_q <= 4'd9;
                    end
                end else if (scl_fall_i) begin
                    if (bit_cnt_q == 4'd8) begin
                        case (slot_q)
                            SLOT_DEV:  ack_q <= dev_ok;
                            SLOT_ADDR: begin
                                ack_q <= addr_ok;
                                sel_q <= shreg_q[2:0];
                            end
                            SLOT_DATA: begin
                                ack_q     <= 1'b1;
                                wr_stb_q  <= 1'b1;
                                wr_data_q <= shreg_q;
                            end
                            default:   ack_q <= 1'b0;
                        endcase
                    end else if (bit_cnt_q == 4'd9) begin
                        ack_q     <= 1'b0;
                        bit_cnt_q <= 4'd0;
                        if (ack_q) slot_q   <= slot_next;
                        else       active_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign ack_o     = ack_q;
    assign wr_stb_o  = wr_stb_q;
    assign wr_sel_o  = sel_q;
    assign wr_data_o = wr_data_q;

    // R10: the pull-down only exists in the ninth-bit slot.
    p_ack_in_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> (bit_cnt_q >= 4'd8));
    // R10: the pull is released at the SCL fall ending the ninth bit.
    p_ack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && scl_fall_i && bit_cnt_q == 4'd9) |=> !ack_q);
    // R8: a device byte is never acknowledged while busy.
    p_no_dev_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_q) && slot_q == SLOT_DEV) |-> !$past(busy_i));
    // R4: an acknowledged register byte has clear upper bits.
    p_addr_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_q) && slot_q == SLOT_ADDR) |-> (shreg_q[7:3] == 5'd0));
endmodule

// File: rtl/qpot_reg_bank.sv
// Register bank: wiper registers, data register rows, status flags and the
// modelled nonvolatile busy counter. Applies each write strobe and starts
// the busy window on STOP after a data row write.
// Assumes NUM_ROWS is a power of two reachable from status bits above bit 0.
module qpot_reg_bank import qpot_pkg::*; #(
    parameter int NUM_CH    = 4,
    parameter int NUM_ROWS  = 2,
    parameter int NV_CYCLES = 2000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb_i,
    input  logic [2:0]               wr_sel_i,
    input  logic [BYTE_W-1:0]        wr_data_i,
    input  logic                     wp_i,
    input  logic                     stop_i,
    output logic                     busy_o,
    output logic [NUM_CH*BYTE_W-1:0] wiper_o
);
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int CNT_W = $clog2(NV_CYCLES + 1);

    logic [BYTE_W-1:0] wiper_q [NUM_CH];
    logic [BYTE_W-1:0] dr_q    [NUM_ROWS][NUM_CH];
    logic              nv_en_q;
    logic [ROW_W-1:0]  row_q;
    logic              pending_q;
    logic [CNT_W-1:0]  busy_cnt_q;

    logic              is_status;
    logic              is_ch;
    logic              nv_path;
    logic [CH_W-1:0]   sel_ch;
    logic [ROW_W-1:0]  new_row;
    logic              unused_status_bits;
    logic [NUM_CH*BYTE_W-1:0] row_flat [NUM_ROWS];

    // Decode of the current write request.
    always_comb begin
        is_status = (wr_sel_i == ADDR_STATUS);
        is_ch     = (wr_sel_i < 3'(NUM_CH));
        nv_path   = nv_en_q & wp_i;
        sel_ch    = wr_sel_i[CH_W-1:0];
        new_row   = wr_data_i[1 +: ROW_W];
    end
    assign unused_status_bits = ^wr_data_i[BYTE_W-1:1+ROW_W];

    // Register updates for status, wiper and data row writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                wiper_q[c] <= '0;
                for (int r = 0; r < NUM_ROWS; r++) dr_q[r][c] <= '0;
            end
            nv_en_q   <= 1'b0;
            row_q     <= '0;
        end else if (wr_stb_i) begin
            if (is_status) begin
                nv_en_q <= wr_data_i[0];
                row_q   <= new_row;
                for (int c = 0; c < NUM_CH; c++) wiper_q[c] <= dr_q[new_row][c];
            end else if (is_ch) begin
                if (nv_path) begin
                    dr_q[row_q][sel_ch] <= wr_data_i;
                    for (int c = 0; c < NUM_CH; c++)
                        wiper_q[c] <= (CH_W'(c) == sel_ch) ? wr_data_i : dr_q[row_q][c];
                end else begin
                    wiper_q[sel_ch] <= wr_data_i;
                end
            end
        end
    end

    // Busy window: armed by a data row write, started at STOP, counted down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q  <= 1'b0;
            busy_cnt_q <= '0;
        end else begin
            if (wr_stb_i && is_ch && !is_status && nv_path)
                pending_q <= 1'b1;
            if (stop_i && pending_q) begin
                pending_q  <= 1'b0;
                busy_cnt_q <= CNT_W'(NV_CYCLES);
            end else if (busy_cnt_q != '0) begin
                busy_cnt_q <= busy_cnt_q - 1'b1;
            end
        end
    end

    assign busy_o = (busy_cnt_q != '0);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_pack
            assign wiper_o[g*BYTE_W +: BYTE_W] = wiper_q[g];
            for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
                assign row_flat[r][g*BYTE_W +: BYTE_W] = dr_q[r][g];
            end
        end
    endgenerate

    // R5: wipers change only on a write strobe.
    p_wiper_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> $stable(wiper_o));
    // R6: after a status write the wipers mirror the selected row.
    p_status_row_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && is_status) |=> (wiper_o == row_flat[row_q]));
    // R8: STOP after a data row write makes the slave busy.
    p_nv_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && pending_q) |=> busy_o);
    // R8: the busy window counts down one per clock.
    p_busy_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt_q != '0 && !(stop_i && pending_q)) |=> (busy_cnt_q == $past(busy_cnt_q) - 1'b1));
endmodule

// File: rtl/qpot_twowire_slave.sv
// Top level of the quad potentiometer two-wire write slave: bus front end,
// byte engine and register bank. wp_i and hw_addr_i are static straps.
module qpot_twowire_slave import qpot_pkg::*; #(
    parameter int NUM_CH      = 4,
    parameter int NUM_ROWS    = 2,
    parameter int NV_CYCLES   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    input  logic                     wp_i,
    input  logic [2:0]               hw_addr_i,
    output logic                     sda_pull_o,
    output logic [NUM_CH*BYTE_W-1:0] wiper_o
);
    logic              sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic              busy, wr_stb;
    logic [2:0]        wr_sel;
    logic [BYTE_W-1:0] wr_data;

    qpot_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_p), .stop_o(stop_p)
    );

    qpot_byte_engine #(.NUM_CH(NUM_CH)) u_engine (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_s),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_p), .stop_i(stop_p), .hw_addr_i(hw_addr_i),
        .busy_i(busy), .ack_o(sda_pull_o), .wr_stb_o(wr_stb),
        .wr_sel_o(wr_sel), .wr_data_o(wr_data)
    );

    qpot_reg_bank #(.NUM_CH(NUM_CH), .NUM_ROWS(NUM_ROWS), .NV_CYCLES(NV_CYCLES)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .wp_i(wp_i), .stop_i(stop_p),
        .busy_o(busy), .wiper_o(wiper_o)
    );
endmodule

// File: tb/qpot_twowire_slave_bench.sv
// Bench: drives byte-write transfers on a wired-AND SDA line, keeps a
// behavioural model of the registers and compares wipers on every clock.
module qpot_twowire_slave_bench;
    localparam int NV = 300;
    localparam int H  = 10;
    localparam logic [2:0] HW = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    logic [31:0] wiper;
    wire  sda_line = sda_drv & ~sda_pull;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    settle = 20;
    bit    run_cmp = 0;
    bit    done = 0;
    string cur_req = "R1";
    longint cyc = 0;

    int m_wiper [4];
    int m_dr [2][4];
    bit m_nv = 0;
    int m_row = 0;
    bit m_pend = 0;
    longint busy_until = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qpot_twowire_slave #(.NV_CYCLES(NV)) u_qpot_twowire_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .wp_i(wp),
        .hw_addr_i(HW), .sda_pull_o(sda_pull), .wiper_o(wiper)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of all wipers against the model.
    always @(negedge clk) begin
        if (settle > 0) settle--;
        else if (run_cmp)
            for (int c = 0; c < 4; c++) check(cur_req, int'(wiper[c*8 +: 8]), m_wiper[c]);
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic pins(input logic s_c, input logic s_d);
        scl = s_c; sda_drv = s_d; settle = 10;
    endtask

    function automatic bit m_dev_ok(input logic [7:0] b);
        if (cyc < busy_until) return 0;
        return (b[7:4] == 4'b0101) && (b[3:1] == HW) && !b[0];
    endfunction
    function automatic bit m_addr_ok(input logic [7:0] b);
        return (b[7:3] == 5'd0) && ((b[2:0] < 3'd4) || (b[2:0] == 3'd7));
    endfunction
    task automatic m_apply(input int adr, input logic [7:0] dat);
        if (adr == 7) begin
            m_nv = dat[0]; m_row = int'(dat[1]);
            for (int c = 0; c < 4; c++) m_wiper[c] = m_dr[m_row][c];
        end else if (m_nv && wp) begin
            m_dr[m_row][adr] = dat;
            for (int c = 0; c < 4; c++) m_wiper[c] = (c == adr) ? int'(dat) : m_dr[m_row][c];
            m_pend = 1;
        end else m_wiper[adr] = dat;
    endtask

    task automatic bus_start();
        pins(1'b1, 1'b1); hold(H);
        pins(1'b1, 1'b0); hold(H);
        pins(1'b0, 1'b0);
    endtask
    task automatic bus_stop();
        hold(H/2); pins(1'b0, 1'b0); hold(H/2);
        pins(1'b1, 1'b0); hold(H);
        pins(1'b1, 1'b1); hold(H);
        if (m_pend) begin busy_until = cyc + NV; m_pend = 0; end
    endtask
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit is_data,
                             input int adr, input string req);
        for (int i = 7; i >= 0; i--) begin
            hold(H/2); pins(1'b0, b[i]); hold(H/2);
            pins(1'b1, b[i]); hold(H/2);
            check("R10 no pull in data bit", int'(sda_pull), 0);
            hold(H/2); pins(1'b0, b[i]);
        end
        if (is_data && exp_ack) m_apply(adr, b);
        hold(H/2); pins(1'b0, 1'b1); hold(H/2);
        pins(1'b1, 1'b1); hold(H/2);
        check(req, int'(sda_pull), int'(exp_ack));
        hold(H/2); pins(1'b0, 1'b1);
    endtask

    // One full byte-write transfer with model-derived expectations.
    task automatic xfer(input logic [7:0] dev, input logic [7:0] adr,
                        input logic [7:0] dat, input bit extra, input string req);
        bit a;
        cur_req = req;
        bus_start();
        a = m_dev_ok(dev);
        send_byte(dev, a, 0, 0, {req, " device ack"});
        if (a) begin
            a = m_addr_ok(adr);
            send_byte(adr, a, 0, 0, {req, " register ack"});
            if (a) begin
                send_byte(dat, 1, 1, int'(adr[2:0]), {req, " data ack"});
                if (extra) send_byte(8'hFF, 0, 0, 0, "R10 extra byte nack");
            end
        end
        bus_stop();
    endtask

    localparam logic [7:0] DEV_W = {4'b0101, HW, 1'b0};

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_wiper[c] = 0; m_dr[0][c] = 0; m_dr[1][c] = 0;
        end
        hold(6); rst_n = 1'b1; hold(4);
        check("R1 reset pull", int'(sda_pull), 0);
        for (int c = 0; c < 4; c++) check("R1 reset wiper", int'(wiper[c*8 +: 8]), 0);
        run_cmp = 1;
        xfer(DEV_W, 8'h02, 8'h3A, 0, "R5 wiper write");
        xfer(DEV_W, 8'h00, 8'h11, 0, "R9 ready after volatile");
        xfer({4'b0101, 3'b100, 1'b0}, 8'h01, 8'h99, 0, "R2 wrong straps");
        xfer({4'b0110, HW, 1'b0}, 8'h01, 8'h99, 0, "R2 wrong nibble");
        xfer({4'b0101, HW, 1'b1}, 8'h01, 8'h99, 0, "R3 read bit");
        xfer(DEV_W, 8'h05, 8'h99, 0, "R4 unused select");
        xfer(DEV_W, 8'h12, 8'h99, 0, "R4 upper bits set");
        xfer(DEV_W, 8'h07, 8'h03, 0, "R6 status row1");
        wp = 1'b1;
        xfer(DEV_W, 8'h01, 8'h5C, 0, "R7 row1 write");
        xfer(DEV_W, 8'h03, 8'h44, 0, "R8 busy nack");
        hold(NV + 60);
        xfer(DEV_W, 8'h03, 8'h44, 0, "R8 ack after busy");
        hold(NV + 60);
        wp = 1'b0;
        xfer(DEV_W, 8'h02, 8'h77, 0, "R5 protect low");
        xfer(DEV_W, 8'h07, 8'h01, 0, "R9 status then ready");
        wp = 1'b1;
        xfer(DEV_W, 8'h00, 8'hA5, 1, "R7 row0 write");
        hold(NV + 60);
        xfer(DEV_W, 8'h07, 8'h03, 0, "R6 switch to row1");
        xfer(DEV_W, 8'h07, 8'h01, 0, "R6 switch to row0");
        xfer(DEV_W, 8'h07, 8'h00, 0, "R6 nv off");
        xfer(DEV_W, 8'h01, 8'h66, 1, "R10 extra after wiper write");
        hold(20);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule